// File: doc/BRIEF.md
# Serial Host Register Bank

This block lets an external host read and write a small bank of byte-wide registers over a four-wire serial link: chip select (active low), serial clock, serial data in and serial data out. The lower part of the bank holds control registers. Their values are driven in parallel to the surrounding logic. The upper part shows status values supplied by that logic, and the host can only read them. All serial pins are brought into the system clock domain, and the whole block runs on the system clock.

Every transfer opens with a command byte, followed by any number of data bytes. The command byte gives the direction and says whether a new address is supplied. A register pointer is kept from one transfer to the next. It advances after each complete data byte, so the host can walk through the bank without sending the address again. While no read data is being driven, the serial output is released through an output-enable signal.

Top module: `spireg_bank`

## Requirements
- R1: After the synchronous reset, every control register is 0, `spi_so_oe_o` is 0 and the register pointer is 0, so a read that does not supply an address starts at address 0.
- R2: Bytes are shifted most significant bit first, and SI is sampled on SCK rising edges. In the command byte, bit 7 = 1 selects a read and 0 a write. Bit 6 = 1 loads the pointer from bits 4:0, and bit 6 = 0 keeps the current pointer. Bit 5 is ignored.
- R3: In a write, each completed data byte is stored into the control register the pointer names, and it appears on that register's slice of `ctrl_o`.
- R4: In a read, SO carries the register the pointer names, most significant bit first. SO changes only after SCK falling edges, and the first bit is valid after the falling edge that follows the last command bit.
- R5: `spi_so_oe_o` is 1 only from the start of the first read data byte until CSB rises. It stays 0 during the command byte, during every write transfer and while CSB is high.
- R6: The pointer advances by one after every complete data byte, whether read or write, and it keeps its value between transfers.
- R7: After address 23 the pointer returns to 0. Addresses 24 to 31 read as 0 and take no writes, and the next address after any of them is 0.
- R8: Reserved bits read as 0 and keep 0 when written. The default reserved bits are address 3 bits 7:4, address 15 bit 7 and address 20 bits 1:0.
- R9: Addresses 16 to 23 are read-only status registers. A write to them changes nothing. A read returns `stat_i` as it stood when the byte's first bit was loaded, so later changes within that byte do not appear.
- R10: Raising CSB ends a transfer at any point. A partly received byte is not written and does not advance the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| spi_csb_i | input | 1 | Chip select, active low, asynchronous |
| spi_sck_i | input | 1 | Serial clock, idles low, asynchronous |
| spi_si_i | input | 1 | Serial data from the host |
| spi_so_o | output | 1 | Serial data to the host |
| spi_so_oe_o | output | 1 | Output enable for SO (0 = released) |
| ctrl_o | output | NUM_CTRL*DATA_W | Control registers; address a sits in bits a*8 +: 8 |
| stat_i | input | (NUM_REGS-NUM_CTRL)*DATA_W | Status values; address 16+k sits in bits k*8 +: 8 |

## Verification
The bench builds the block with its default parameters: 24 registers, 16 of them control, a two-stage synchronizer and the default reserved-bit mask. With a 5-bit address field, these values let random commands land on the unused addresses 24 to 31. The pointer wrap after 23 can be reached within a few bytes, so multi-byte bursts regularly run across the boundary between control and status registers and back to 0. Because the status inputs change during read bytes, capture at the start of each byte is tested under random traffic as well as in directed cases.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  typedef enum logic [0:0] {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } spireg_phase_e;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[s] <= RST_VAL;
        else       stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[s] <= RST_VAL;
        else       stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spireg_link.sv
module spireg_link
  import spireg_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              csb_s_i,
  input  logic              sck_s_i,
  input  logic              si_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              so_o,
  output logic              so_oe_o
);
  localparam int BIT_CW   = $clog2(DATA_W);
  localparam int RW_BIT   = DATA_W - 1;
  localparam int MODE_BIT = DATA_W - 2;

  logic              sck_d_q;
  logic [BIT_CW-1:0] bit_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] tx_q;
  spireg_phase_e     phase_q;
  logic              rd_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              oe_q;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  logic              sck_rise;
  logic              sck_fall;
  logic              last_bit;
  logic [DATA_W-1:0] rx_full;

  function automatic logic [ADDR_W-1:0] next_ptr(input logic [ADDR_W-1:0] a);
    if (int'(a) >= NUM_REGS - 1) return '0;
    return a + 1'b1;
  endfunction

  assign sck_rise = sck_s_i & ~sck_d_q;
  assign sck_fall = ~sck_s_i & sck_d_q;
  assign last_bit = (bit_q == BIT_CW'(DATA_W - 1));
  assign rx_full  = {rx_q[DATA_W-2:0], si_s_i};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sck_d_q   <= 1'b0;
      bit_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      phase_q   <= PH_CMD;
      rd_q      <= 1'b0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      sck_d_q <= sck_s_i;
      wr_en_q <= 1'b0;
      if (csb_s_i) begin
        bit_q   <= '0;
        phase_q <= PH_CMD;
        rd_q    <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_q  <= rx_full;
          bit_q <= last_bit ? '0 : bit_q + 1'b1;
          if (last_bit) begin
            if (phase_q == PH_CMD) begin
              phase_q <= PH_DATA;
              rd_q    <= rx_full[RW_BIT];
              if (rx_full[MODE_BIT]) ptr_q <= rx_full[ADDR_W-1:0];
            end else begin
              ptr_q <= next_ptr(ptr_q);
              if (!rd_q) begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= rx_full;
              end
            end
          end
        end
        if (sck_fall && phase_q == PH_DATA && rd_q) begin
          if (bit_q == '0) begin
            tx_q <= rd_data_i;
            oe_q <= 1'b1;
          end else begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign so_o      = oe_q & tx_q[DATA_W-1];
  assign so_oe_o   = oe_q;
endmodule

// File: rtl/spireg_store.sv
module spireg_store #(
  parameter int                      NUM_REGS  = 24,
  parameter int                      NUM_CTRL  = 16,
  parameter int                      DATA_W    = 8,
  parameter int                      ADDR_W    = 5,
  parameter logic [NUM_REGS*DATA_W-1:0] RSVD_MASK = '0
) (
  input  logic                                 clk_i,
  input  logic                                 rst_i,
  input  logic                                 wr_en_i,
  input  logic [ADDR_W-1:0]                    wr_addr_i,
  input  logic [DATA_W-1:0]                    wr_data_i,
  input  logic [ADDR_W-1:0]                    rd_addr_i,
  input  logic [(NUM_REGS-NUM_CTRL)*DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0]                    rd_data_o,
  output logic [NUM_CTRL*DATA_W-1:0]           ctrl_o
);
  logic [DATA_W-1:0] ctrl_q [NUM_CTRL];
  logic [DATA_W-1:0] view   [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] KEEP = ~RSVD_MASK[g*DATA_W +: DATA_W];
    if (g < NUM_CTRL) begin : g_ctrl
      always_ff @(posedge clk_i) begin
        if (rst_i)
          ctrl_q[g] <= '0;
        else if (wr_en_i && int'(wr_addr_i) == g)
          ctrl_q[g] <= wr_data_i & KEEP;
      end
      assign ctrl_o[g*DATA_W +: DATA_W] = ctrl_q[g];
      assign view[g] = ctrl_q[g];
    end else begin : g_stat
      assign view[g] = stat_i[(g-NUM_CTRL)*DATA_W +: DATA_W] & KEEP;
    end
  end

  assign rd_data_o = (int'(rd_addr_i) < NUM_REGS) ? view[rd_addr_i] : '0;
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank #(
  parameter int NUM_REGS    = 24,
  parameter int NUM_CTRL    = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_REGS*DATA_W-1:0] RSVD_MASK =
      ((NUM_REGS*DATA_W)'(8'hF0) << (3*DATA_W))  |
      ((NUM_REGS*DATA_W)'(8'h80) << (15*DATA_W)) |
      ((NUM_REGS*DATA_W)'(8'h03) << (20*DATA_W))
) (
  input  logic                                 clk_i,
  input  logic                                 rst_i,
  input  logic                                 spi_csb_i,
  input  logic                                 spi_sck_i,
  input  logic                                 spi_si_i,
  output logic                                 spi_so_o,
  output logic                                 spi_so_oe_o,
  output logic [NUM_CTRL*DATA_W-1:0]           ctrl_o,
  input  logic [(NUM_REGS-NUM_CTRL)*DATA_W-1:0] stat_i
);
  localparam int ADDR_W = $clog2(NUM_REGS);

  logic [2:0]        pins_s;
  logic              csb_s;
  logic              sck_s;
  logic              si_s;
  logic [ADDR_W-1:0] addr_cnt;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  spireg_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .d_i  ({spi_csb_i, spi_sck_i, spi_si_i}),
    .q_o  (pins_s)
  );

  assign {csb_s, sck_s, si_s} = pins_s;

  spireg_link #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_link (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .csb_s_i  (csb_s),
    .sck_s_i  (sck_s),
    .si_s_i   (si_s),
    .rd_data_i(rd_data),
    .ptr_o    (addr_cnt),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .so_o     (spi_so_o),
    .so_oe_o  (spi_so_oe_o)
  );

  spireg_store #(
    .NUM_REGS (NUM_REGS),
    .NUM_CTRL (NUM_CTRL),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .RSVD_MASK(RSVD_MASK)
  ) u_store (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(addr_cnt),
    .stat_i   (stat_i),
    .rd_data_o(rd_data),
    .ctrl_o   (ctrl_o)
  );
endmodule

// File: rtl/spireg_bank_chk.sv
module spireg_bank_chk #(
  parameter int NUM_REGS = 24,
  parameter int NUM_CTRL = 16,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5,
  parameter logic [NUM_REGS*DATA_W-1:0] RSVD_MASK = '0
) (
  input logic                       clk_i,
  input logic                       rst_i,
  input logic                       csb_s,
  input logic                       so_oe,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [ADDR_W-1:0]          cnt,
  input logic [NUM_CTRL*DATA_W-1:0] ctrl
);
  localparam logic [NUM_CTRL*DATA_W-1:0] CMASK = RSVD_MASK[NUM_CTRL*DATA_W-1:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (ctrl == '0 && !so_oe && cnt == '0));

  // R8
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl & CMASK) == '0);

  // R10
  no_stray_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_en |=> $stable(ctrl));

  // R9
  ro_write_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en && int'(wr_addr) >= NUM_CTRL) |=> $stable(ctrl));

  // R7
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en && int'(wr_addr) == NUM_REGS - 1) |-> cnt == '0);

  // R5
  oe_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    csb_s |=> !so_oe);
endmodule

bind spireg_bank spireg_bank_chk #(
  .NUM_REGS (NUM_REGS),
  .NUM_CTRL (NUM_CTRL),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .RSVD_MASK(RSVD_MASK)
) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .csb_s  (csb_s),
  .so_oe  (spi_so_oe_o),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .cnt    (addr_cnt),
  .ctrl   (ctrl_o)
);

// File: tb/spireg_bank_bench.sv
module spireg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int NR = 24;
  localparam int NC = 16;
  localparam int DW = 8;
  localparam int NS = NR - NC;
  localparam logic [NR*DW-1:0] MASK =
      ((NR*DW)'(8'hF0) << (3*DW)) | ((NR*DW)'(8'h80) << (15*DW)) | ((NR*DW)'(8'h03) << (20*DW));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csb = 1'b1;
  logic sck = 1'b0;
  logic si  = 1'b0;
  logic so;
  logic so_oe;
  logic [NC*DW-1:0] ctrl;
  logic [NS*DW-1:0] stat = '0;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] mdl [NR];
  int  mptr  = 0;
  bit  scram = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rx_b;
  bit oe_any;
  bit oe_all;

  always #(CLK_PERIOD/2) clk = ~clk;

  spireg_bank u_spireg_bank (
    .clk_i      (clk),
    .rst_i      (rst),
    .spi_csb_i  (csb),
    .spi_sck_i  (sck),
    .spi_si_i   (si),
    .spi_so_o   (so),
    .spi_so_oe_o(so_oe),
    .ctrl_o     (ctrl),
    .stat_i     (stat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int a);
    return (a >= NR - 1) ? 0 : a + 1;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a >= NR) return 8'h00;
    if (a < NC)  return mdl[a];
    return stat[(a-NC)*DW +: DW] & ~MASK[a*DW +: DW];
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One byte: SI set before each rise, SO sampled just before the rise (R2, R4)
  task automatic xbyte(input logic [7:0] tx);
    oe_any = 1'b0;
    oe_all = 1'b1;
    for (int b = 7; b >= 0; b--) begin
      si = tx[b];
      wait_n(HALF);
      rx_b[b] = so;
      oe_any |= so_oe;
      oe_all &= so_oe;
      sck = 1'b1;
      if (b == 3 && scram) stat = {$urandom, $urandom};
      wait_n(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic begin_txn();
    csb = 1'b0;
    wait_n(HALF);
  endtask

  task automatic end_txn();
    wait_n(HALF);
    csb = 1'b1;
    wait_n(HALF);
    chk("R5 idle oe", {31'b0, so_oe}, 32'h0);
  endtask

  task automatic wr_txn(input bit rnd, input int addr, input int n);
    begin_txn();
    xbyte({1'b0, rnd, 1'b0, 5'(addr)});
    if (rnd) mptr = addr;
    for (int k = 0; k < n; k++) begin
      xbyte(wbuf[k]);
      chk("R5 write oe", {31'b0, oe_any}, 32'h0);
      if (mptr < NC) mdl[mptr] = wbuf[k] & ~MASK[mptr*DW +: DW];
      mptr = nxt(mptr);
    end
    end_txn();
    for (int a = 0; a < NC; a++)
      chk("R3 ctrl_o", {24'b0, ctrl[a*DW +: DW]}, {24'b0, mdl[a]});
  endtask

  task automatic rd_txn(input bit rnd, input int addr, input int n);
    logic [7:0] e;
    begin_txn();
    xbyte({1'b1, rnd, 1'b1, 5'(addr)});
    chk("R5 cmd oe", {31'b0, oe_any}, 32'h0);
    if (rnd) mptr = addr;
    for (int k = 0; k < n; k++) begin
      e = exp_rd(mptr);
      xbyte(8'h00);
      chk("R4 R9 read data", {24'b0, rx_b}, {24'b0, e});
      chk("R5 read oe", {31'b0, oe_all}, 32'h1);
      mptr = nxt(mptr);
    end
    end_txn();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int a = 0; a < NR; a++) mdl[a] = 8'h00;
    wait_n(5);
    rst = 1'b0;
    wait_n(4);
    // R1 reset state
    chk("R1 ctrl reset", {31'b0, ctrl == '0}, 32'h1);
    chk("R1 oe reset", {31'b0, so_oe}, 32'h0);
    stat = 64'h8877_6655_4433_2211;
    rd_txn(1'b0, 0, 1);                 // R1 pointer starts at 0
    // R8 reserved nibble of address 3
    wbuf[0] = 8'hFF;
    wr_txn(1'b1, 3, 1);
    chk("R8 ctrl reserved", {24'b0, ctrl[3*DW +: DW]}, 32'h0F);
    // R7 R9 burst through status into wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'hC3; wbuf[3] = 8'h5A;
    wr_txn(1'b1, 22, 4);
    chk("R7 wrap write", {24'b0, ctrl[0 +: DW]}, 32'hC3);
    // R6 continue from pointer (now 2)
    rd_txn(1'b0, 31, 3);
    // R7 unused address reads 0 and next is 0
    rd_txn(1'b1, 29, 2);
    wbuf[0] = 8'h77;
    wr_txn(1'b1, 27, 1);
    // R8 status reserved bits, R9 status read
    stat = 64'hFFFF_FFFF_FFFF_FFFF;
    rd_txn(1'b1, 20, 1);
    // R10 abort mid data byte
    wbuf[0] = 8'hA5;
    wr_txn(1'b1, 5, 1);
    begin_txn();
    xbyte({1'b0, 1'b0, 1'b0, 5'd0});
    for (int b = 0; b < 4; b++) begin
      si = 1'b1; wait_n(HALF); sck = 1'b1; wait_n(HALF); sck = 1'b0;
    end
    end_txn();
    chk("R10 partial not written", {24'b0, ctrl[6*DW +: DW]}, {24'b0, mdl[6]});
    // R10 abort inside command byte: pointer kept
    begin_txn();
    for (int b = 0; b < 5; b++) begin
      si = 1'b1; wait_n(HALF); sck = 1'b1; wait_n(HALF); sck = 1'b0;
    end
    end_txn();
    rd_txn(1'b0, 0, 2);
    // random traffic with status changing inside read bytes (R9)
    scram = 1'b1;
    for (int it = 0; it < 40; it++) begin
      int n;
      bit rnd;
      int addr;
      n = 1 + int'($urandom % 4);
      rnd = $urandom % 2;
      addr = int'($urandom % 32);
      for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
      if ($urandom % 2) wr_txn(rnd, addr, n);
      else              rd_txn(rnd, addr, n);
    end
    scram = 1'b0;
    finish_run();
  end
endmodule